// File: doc/BRIEF.md
# Serial PHY Management Master with Local Register Aliasing

This block runs clause-22 management transactions towards external PHYs over a two-wire serial bus. A client hands over a single request: a direction bit, a 5-bit PHY address, a register address and 16 bits of write data. The block then produces the management clock and the outgoing data bit with its output enable, and for reads it samples the incoming data bit. When the transaction ends, `rsp_done` pulses for one cycle and, for reads, `rsp_rdata` holds the result.

Some requests never reach the wire. A register address with any bit set above bit 4 is rejected at once. When aliasing is enabled, one PHY address (`ALIAS_PHY`, 30 by default) is served from a small local register file that backs eleven register numbers. Every serial transaction starts with a run of ones long enough for the PHY to synchronise. A read ends with nineteen released bit times and a write ends with two.

The controller has five states. `ST_IDLE` waits for a request. On acceptance it moves to `ST_LOCAL` (rejected or aliased request) or to `ST_PRE` (serial request). `ST_LOCAL` returns to `ST_IDLE` after one cycle. `ST_PRE` moves to `ST_CMD` after the preamble. `ST_CMD` moves to `ST_TAIL` after the last driven bit. `ST_TAIL` returns to `ST_IDLE` after the last released bit. Serial states advance only at the end of a bit period.

Top module: `mdio_master`

## Requirements
- R1: After reset `req_ready` is 1 and `busy`, `mdc`, `mdio_oe` and `rsp_done` are 0.
- R2: Each serial bit lasts 2·`HALF_DIV` system clocks: `mdc` is low for `HALF_DIV` clocks, then high for `HALF_DIV` clocks, and `mdio_o` changes only while `mdc` is low. `HALF_DIV` must be chosen so that `mdc` does not exceed 2.5 MHz.
- R3: Every serial transaction begins with 33 `mdc` rising edges during which `mdio_oe`=1 and `mdio_o`=1.
- R4: After the preamble, a read drives 16 bits MSB first: 1,1, then 0,1, then 1,0, then PHY address[4:0], then register address[4:0].
- R5: After the read command, `mdio_oe` is 0 for 19 bit periods. `mdio_i` is sampled in the last system clock of each low phase. The samples from bit periods 3 to 18 form `rsp_rdata`, MSB first.
- R6: After the preamble, a write drives 32 bits MSB first: 0,1, 0,1, PHY address, register address, 1,0, and the 16 data bits. It then holds `mdio_oe` at 0 for 2 bit periods.
- R7: `req_ready` is 1 exactly when `busy` is 0. A request presented while busy is not taken, and it is accepted in the cycle `req_ready` returns.
- R8: A register address with any bit above bit 4 set finishes with `rsp_done` two cycles after the request is presented, with no `mdc` edge. Such a read returns 0xFFFF and such a write changes nothing.
- R9: With aliasing enabled and PHY address `ALIAS_PHY`, register numbers 0–6, 17, 29, 30 and 31 are served from local storage that resets to 0x0000. Writes store the data, reads return it, and neither produces an `mdc` edge.
- R10: For the alias PHY, a read of any other register number returns 0xFFFF and a write to it is dropped.
- R11: `rsp_done` is a single-cycle pulse, `busy` is low in that cycle, and `rsp_rdata` carries the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_W | Register address (valid range 0–31) |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Outgoing data bit |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Incoming data bit from the pad |

## Verification
The completion of one transaction and the acceptance of the next can fall in the same cycle. `req_ready` returns together with the `rsp_done` pulse, so a request held at the port is taken on that very edge. The bench holds an aliased read at the port for the whole of a serial read. It then checks that `req_ready` stayed low until the end, that the serial frame kept its full edge count and data, and that the held request completed right after with the aliased value.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCAL,
        ST_PRE,
        ST_CMD,
        ST_TAIL
    } mdio_state_e;

    localparam int PRE_BITS    = 33;
    localparam int RD_CMD_BITS = 16;
    localparam int WR_CMD_BITS = 32;
    localparam int RD_TAIL     = 19;
    localparam int WR_TAIL     = 2;
    localparam int DATA_W      = 16;
    localparam int NSLOT       = 11;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic bit_end
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        mdc     = mdc_q;
        rise    = run && !mdc_q && (cnt_q == LAST);
        bit_end = run &&  mdc_q && (cnt_q == LAST);
    end

    // R2: a high phase never starts while the block is stopped
    p_mdc_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc_q);

endmodule

// File: rtl/mdio_alias_regs.sv
module mdio_alias_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);
    logic [3:0]        slot;
    logic [DATA_W-1:0] slot_q [NSLOT];

    always_comb begin
        hit  = 1'b1;
        slot = 4'd0;
        if (addr <= 5'd6) begin
            slot = addr[3:0];
        end else if (addr == 5'd17) begin
            slot = 4'd7;
        end else if (addr >= 5'd29) begin
            slot = 4'(addr - 5'd21);
        end else begin
            hit = 1'b0;
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && hit && slot == 4'(g))
                slot_q[g] <= wdata;
        end
    end

    assign rdata = hit ? slot_q[slot] : {DATA_W{1'b1}};

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV  = 50,
    parameter int REG_W     = 8,
    parameter bit ALIAS_EN  = 1'b1,
    parameter int ALIAS_PHY = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [4:0]        req_phy,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_state_e state_q, state_d;

    logic              wr_q, bad_q;
    logic [4:0]        reg_q;
    logic [DATA_W-1:0] wdata_q, cap_q, rdata_q;
    logic [31:0]       shreg_q;
    logic [5:0]        bitcnt_q;
    logic              done_q;
    logic              run, rise, bit_end;
    logic              accept, to_local;
    logic [5:0]        cmd_last, tail_last;
    logic              al_hit;
    logic [DATA_W-1:0] al_rdata;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign to_local  = (req_reg[REG_W-1:5] != '0) ||
                       (ALIAS_EN && (req_phy == 5'(ALIAS_PHY)));
    assign cmd_last  = wr_q ? 6'(WR_CMD_BITS - 1) : 6'(RD_CMD_BITS - 1);
    assign tail_last = wr_q ? 6'(WR_TAIL - 1)     : 6'(RD_TAIL - 1);
    assign run       = (state_q == ST_PRE) || (state_q == ST_CMD) ||
                       (state_q == ST_TAIL);

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .mdc    (mdc),
        .rise   (rise),
        .bit_end(bit_end)
    );

    if (ALIAS_EN) begin : g_alias
        mdio_alias_regs u_alias (
            .clk  (clk),
            .rst_n(rst_n),
            .addr (reg_q),
            .wr_en((state_q == ST_LOCAL) && wr_q && !bad_q),
            .wdata(wdata_q),
            .hit  (al_hit),
            .rdata(al_rdata)
        );
    end else begin : g_no_alias
        assign al_hit   = 1'b0;
        assign al_rdata = {DATA_W{1'b1}};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = to_local ? ST_LOCAL : ST_PRE;
            ST_LOCAL: state_d = ST_IDLE;
            ST_PRE:   if (bit_end && bitcnt_q == 6'(PRE_BITS - 1)) state_d = ST_CMD;
            ST_CMD:   if (bit_end && bitcnt_q == cmd_last) state_d = ST_TAIL;
            ST_TAIL:  if (bit_end && bitcnt_q == tail_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            bad_q    <= 1'b0;
            reg_q    <= '0;
            wdata_q  <= '0;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            cap_q    <= '0;
            rdata_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                wr_q     <= req_write;
                bad_q    <= (req_reg[REG_W-1:5] != '0);
                reg_q    <= req_reg[4:0];
                wdata_q  <= req_wdata;
                bitcnt_q <= '0;
                shreg_q  <= req_write
                    ? {2'b01, 2'b01, req_phy, req_reg[4:0], 2'b10, req_wdata}
                    : {2'b11, 2'b01, 2'b10, req_phy, req_reg[4:0], 16'h0000};
            end
            if (state_q == ST_LOCAL) begin
                done_q <= 1'b1;
                if (!wr_q)
                    rdata_q <= (bad_q || !al_hit) ? {DATA_W{1'b1}} : al_rdata;
            end
            if (run && bit_end)
                bitcnt_q <= (state_d != state_q) ? 6'd0 : bitcnt_q + 6'd1;
            if (state_q == ST_CMD && bit_end)
                shreg_q <= {shreg_q[30:0], 1'b0};
            if (state_q == ST_TAIL && rise && !wr_q &&
                bitcnt_q >= 6'd2 && bitcnt_q <= 6'd17)
                cap_q <= {cap_q[DATA_W-2:0], mdio_i};
            if (state_q == ST_TAIL && bit_end && bitcnt_q == tail_last) begin
                done_q <= 1'b1;
                if (!wr_q) rdata_q <= cap_q;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        rsp_done  = done_q;
        rsp_rdata = rdata_q;
        mdio_oe   = 1'b0;
        mdio_o    = 1'b0;
        unique case (state_q)
            ST_PRE: begin mdio_oe = 1'b1; mdio_o = 1'b1;        end
            ST_CMD: begin mdio_oe = 1'b1; mdio_o = shreg_q[31]; end
            default: ;
        endcase
    end

    // R1: the clock rests low whenever the block is idle
    p_idle_mdc_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R3: preamble bits are driven ones
    p_preamble_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE) |-> (mdio_oe && mdio_o));
    // R5: the pad is released during the trailing bits
    p_tail_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> !mdio_oe);
    // R7: no second request while a transaction runs
    p_no_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);
    // R8: locally served requests never clock the bus
    p_local_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCAL) |-> !mdc);
    // R11: completion is a single pulse, issued after a busy cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_done) |-> ($past(busy) && !busy));

endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam int HALF = 4;
    localparam int NV   = 16;
    // {wr, phy[4:0], reg[7:0], wdata[15:0], phy_resp[15:0], expected[15:0]}
    localparam logic [61:0] VEC [NV] = '{
        {1'b0, 5'd1,  8'h01, 16'h0000, 16'hA5C3, 16'hA5C3},
        {1'b1, 5'd3,  8'h04, 16'h1234, 16'h0000, 16'h0000},
        {1'b0, 5'd31, 8'h1F, 16'h0000, 16'h0001, 16'h0001},
        {1'b0, 5'd0,  8'h02, 16'h0000, 16'h8000, 16'h8000},
        {1'b1, 5'd30, 8'h00, 16'hBEEF, 16'h0000, 16'h0000},
        {1'b0, 5'd30, 8'h00, 16'h0000, 16'h0000, 16'hBEEF},
        {1'b1, 5'd30, 8'h11, 16'h0F0F, 16'h0000, 16'h0000},
        {1'b0, 5'd30, 8'h11, 16'h0000, 16'h0000, 16'h0F0F},
        {1'b1, 5'd30, 8'h07, 16'h5555, 16'h0000, 16'h0000},
        {1'b0, 5'd30, 8'h07, 16'h0000, 16'h0000, 16'hFFFF},
        {1'b0, 5'd30, 8'h1F, 16'h0000, 16'h0000, 16'h0000},
        {1'b0, 5'd2,  8'h20, 16'h0000, 16'h1111, 16'hFFFF},
        {1'b1, 5'd30, 8'h40, 16'h1111, 16'h0000, 16'h0000},
        {1'b0, 5'd30, 8'h00, 16'h0000, 16'h0000, 16'hBEEF},
        {1'b1, 5'd5,  8'h21, 16'h2222, 16'h0000, 16'h0000},
        {1'b0, 5'd30, 8'h1D, 16'h0000, 16'h0000, 16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [4:0] req_phy = '0;
    logic [7:0] req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, rsp_done, busy, mdc, mdio_o, mdio_oe;
    logic [15:0] rsp_rdata;
    logic mdio_i = 1'b1;

    int n_checks = 0, n_err = 0;
    int edge_n = 0;
    logic cur_rd = 1'b0;
    logic [15:0] cur_resp = '0;
    logic rec_oe [128];
    logic rec_bit [128];
    realtime t_rise [2];
    realtime t_fall0;

    always #2 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: records each rising edge and presents the next read bit
    always @(posedge mdc) begin
        if (edge_n < 128) begin
            rec_oe[edge_n]  = mdio_oe;
            rec_bit[edge_n] = mdio_o;
        end
        if (edge_n < 2) t_rise[edge_n] = $realtime;
        edge_n = edge_n + 1;
        if (cur_rd && edge_n + 1 >= 50 && edge_n + 1 <= 68) begin
            int r;
            r = edge_n + 1 - 49;
            if (r == 2)                mdio_i <= 1'b0;
            else if (r >= 3 && r <= 18) mdio_i <= cur_resp[18 - r];
            else                        mdio_i <= 1'b1;
        end else begin
            mdio_i <= 1'b1;
        end
    end

    always @(negedge mdc) if (edge_n == 1) t_fall0 = $realtime;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] frame_word(input logic wr, input logic [4:0] phy,
                                               input logic [4:0] rg, input logic [15:0] d);
        if (wr) return {2'b01, 2'b01, phy, rg, 2'b10, d};
        return {16'h0000, 2'b11, 2'b01, 2'b10, phy, rg};
    endfunction

    task automatic run_vec(input logic [61:0] v);
        logic wr; logic [4:0] phy; logic [7:0] rg; logic [15:0] wd, resp, exp;
        bit serial; int lat, ncmd, ntail, bad; logic [31:0] fw; logic eb;
        {wr, phy, rg, wd, resp, exp} = v;
        serial = (rg < 8'd32) && (phy != 5'd30);
        edge_n = 0; cur_rd = !wr; cur_resp = resp;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 3000) begin @(negedge clk); lat++; end
        check(rsp_done == 1'b1 && busy == 1'b0, "R11 done with busy low", {rsp_done, busy}, 2'b10);
        if (!wr) check(rsp_rdata == exp, serial ? "R5 read data" : (rg >= 32 ? "R8 bad read" : "R9 R10 alias read"),
                       rsp_rdata, exp);
        if (serial) begin
            ncmd = wr ? 32 : 16; ntail = wr ? 2 : 19;
            check(edge_n == 33 + ncmd + ntail, wr ? "R6 write edge count" : "R5 read edge count",
                  edge_n, 33 + ncmd + ntail);
            fw = frame_word(wr, phy, rg[4:0], wd);
            bad = 0;
            for (int i = 0; i < 33 + ncmd + ntail; i++) begin
                if (i < 33) eb = 1'b1;
                else if (i < 33 + ncmd) eb = fw[ncmd - 1 - (i - 33)];
                else eb = 1'bx;
                if (i < 33 + ncmd) begin
                    if (rec_oe[i] !== 1'b1 || rec_bit[i] !== eb) bad++;
                end else if (rec_oe[i] !== 1'b0) bad++;
            end
            check(bad == 0, wr ? "R3 R6 write frame bits" : "R3 R4 read frame bits", bad, 0);
        end else begin
            check(edge_n == 0 && lat == 2, "R8 R9 local latency, no clock", {edge_n[15:0], lat[15:0]}, 32'h0000_0002);
        end
        @(negedge clk);
        check(rsp_done == 1'b0, "R11 single-cycle done", rsp_done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        int lat, ready_bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !busy && !mdc && !mdio_oe && !rsp_done, "R1 reset state",
              {req_ready, busy, mdc, mdio_oe, rsp_done}, 5'b10000);

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R7 + R2: hold an aliased read at the port through a serial read
        edge_n = 0; cur_rd = 1'b1; cur_resp = 16'h3C5A;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = 5'd7; req_reg = 8'h03;
        @(negedge clk);
        req_phy = 5'd30; req_reg = 8'h00;
        lat = 1; ready_bad = 0;
        while (!rsp_done && lat < 3000) begin
            if (req_ready) ready_bad++;
            @(negedge clk); lat++;
        end
        check(ready_bad == 0, "R7 ready low while busy", ready_bad, 0);
        check(rsp_rdata == 16'h3C5A && edge_n == 68, "R7 serial read intact",
              {rsp_rdata, edge_n[15:0]}, {16'h3C5A, 16'd68});
        check(req_ready == 1'b1, "R7 ready returns with done", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R7 held request taken at done", busy, 1);
        @(negedge clk);
        check(rsp_done && rsp_rdata == 16'hBEEF, "R7 R9 held request result",
              {rsp_done, rsp_rdata}, {1'b1, 16'hBEEF});
        check((t_rise[1] - t_rise[0]) == 2.0 * HALF * 4.0, "R2 bit period",
              int'(t_rise[1] - t_rise[0]), 2 * HALF * 4);
        check((t_fall0 - t_rise[0]) == HALF * 4.0, "R2 high phase",
              int'(t_fall0 - t_rise[0]), HALF * 4);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule